// File: doc/BRIEF.md
# SDRAM Self-Refresh Command Sequencer

This block sits between a software-writable 3-bit command port and the control pins of an SDRAM. Software writes one of three codes: close every bank, put the device into self refresh, or bring it back out. Each accepted write makes the block issue one bus command and then hold off further commands until that command's minimum timing has passed. In normal operation a refresh interval timer issues auto-refresh commands on its own. It first closes any open bank with a precharge. It waits for an access that is already running to finish before it does so.

Memory traffic is modelled as a request/grant handshake. Each grant opens a bank for a fixed access time. During self refresh the clock-enable pin is held low and the SDRAM clock is gated off. Requests are refused, and no refresh is issued from outside. Leaving self refresh restarts the clock before clock-enable rises and then waits out the exit recovery time. A reset always returns the block to normal mode with the refresh timer switched off. The timer stays off until software turns it on again through its enable write port.

Top module: `sdr_sref_seq`

## Requirements
- R1: After reset: `sd_cke_o`=1, `sd_clk_en_o`=1, `sd_dqm_o`=1, pins carry NOP ({cs,ras,cas,we}=0111), `busy_o`=0, `sref_o`=0, and the refresh timer is disabled.
- R2: A write of code 3'b010 while idle puts a precharge-all (pins 0010) on the bus in the next cycle. `busy_o` then stays high for exactly TRP cycles.
- R3: A write of code 3'b101 while idle, with all banks closed, puts an auto-refresh pattern (pins 0001) on the bus in the next cycle with `sd_cke_o` low in that same cycle. `sd_cke_o` stays low and `sref_o` stays high until exit.
- R4: A write of code 3'b101 when no precharge has closed the banks since reset or since the last grant raises `err_o` for one cycle. In that case the block issues no command and `sd_cke_o` stays high.
- R5: From the cycle after self-refresh entry, `sd_clk_en_o` is low and no refresh command appears, even when the refresh timer is enabled.
- R6: A request while `sref_o` is high gives `rej_o`=1 in the next cycle and is never granted.
- R7: A write of code 3'b110 in self refresh raises `sd_clk_en_o` in the next cycle. `sd_cke_o` rises TWAKE cycles later, with NOP on the pins, and `busy_o` is high for TWAKE+TXSR cycles in total.
- R8: With the timer enabled (via `arf_we_i`/`arf_en_i`), auto-refresh commands are issued about every REF_INT cycles. No refresh is issued while a bank is open; a precharge comes first.
- R9: No precharge or refresh command is issued during the TACC cycles of an access in progress.
- R10: Command writes while `busy_o` is high are ignored. So are codes other than the three listed, and codes that do not fit the current state (3'b110 when idle, 3'b010 or 3'b101 in self refresh).
- R11: A reset during self refresh returns the block to normal mode, with no refresh issued until the timer is enabled again.
- R12: A request while idle and with no refresh due gives a one-cycle `gnt_o`, an activate on the pins (0011) and `sd_dqm_o`=0 in the next cycle. `busy_o` then stays high for TACC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_i | input | 3 | Command code |
| arf_we_i | input | 1 | Refresh-timer enable write strobe |
| arf_en_i | input | 1 | Refresh-timer enable value |
| req_i | input | 1 | Memory access request |
| gnt_o | output | 1 | Access granted (one cycle) |
| rej_o | output | 1 | Access refused during self refresh |
| err_o | output | 1 | Self-refresh entry refused, banks not closed |
| busy_o | output | 1 | Command timing in progress |
| sref_o | output | 1 | Device in self refresh |
| sd_cs_n_o | output | 1 | SDRAM chip select, active low |
| sd_ras_n_o | output | 1 | SDRAM row strobe, active low |
| sd_cas_n_o | output | 1 | SDRAM column strobe, active low |
| sd_we_n_o | output | 1 | SDRAM write enable, active low |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_clk_en_o | output | 1 | Gate for the SDRAM clock output |
| sd_dqm_o | output | 1 | Data mask, high outside accesses |

## Verification
Directed sequences first try entry without a prior precharge, a write that lands while busy, an unknown code, and entry, requests and exit around a closed-bank state. These separate the legal-order path from each refusal path, and they pin down the exact cycle of each pin change. A random phase of requests with the timer running separates correct refresh spacing and precharge-before-refresh ordering from refreshes that cut into accesses. A second random phase mixes in command writes of every code, so that entry, exit and refusals meet requests in many orders. A reset taken mid self refresh shows that the timer stays off afterwards.

// File: rtl/sdr_sref_pkg.sv
package sdr_sref_pkg;

  localparam logic [2:0] OP_PRE_ALL  = 3'b010;
  localparam logic [2:0] OP_SR_ENTER = 3'b101;
  localparam logic [2:0] OP_SR_EXIT  = 3'b110;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t PIN_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pin_cmd_t PIN_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam pin_cmd_t PIN_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam pin_cmd_t PIN_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_PRE,
    ST_ARF,
    ST_SREF,
    ST_WAKE,
    ST_XSR
  } seq_state_e;

endpackage

// File: rtl/sdr_wait_cnt.sv
module sdr_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int INTERVAL = 390
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ack_i,
  output logic due_o
);

  localparam int CW = $clog2(INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          due_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      due_q <= wrap | (due_q & ~ack_i);
    end
  end

  assign due_o = due_q;

  a_r8_ack_clears_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ack_i && !wrap) |=> !due_o);

  a_r11_idle_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !due_o);

endmodule

// File: rtl/sdr_sref_seq.sv
module sdr_sref_seq
  import sdr_sref_pkg::*;
#(
  parameter int TRP     = 3,
  parameter int TRFC    = 7,
  parameter int TACC    = 4,
  parameter int TWAKE   = 2,
  parameter int TXSR    = 10,
  parameter int REF_INT = 390
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [2:0] cmd_i,
  input  logic       arf_we_i,
  input  logic       arf_en_i,
  input  logic       req_i,
  output logic       gnt_o,
  output logic       rej_o,
  output logic       err_o,
  output logic       busy_o,
  output logic       sref_o,
  output logic       sd_cs_n_o,
  output logic       sd_ras_n_o,
  output logic       sd_cas_n_o,
  output logic       sd_we_n_o,
  output logic       sd_cke_o,
  output logic       sd_clk_en_o,
  output logic       sd_dqm_o
);

  localparam int M1   = (TRP > TRFC) ? TRP : TRFC;
  localparam int M2   = (TACC > TWAKE) ? TACC : TWAKE;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > TXSR) ? M3 : TXSR;
  localparam int WW   = $clog2(MAXT) + 1;

  seq_state_e st_q, st_d;
  pin_cmd_t   pin_q, pin_d;
  logic       cke_q, cke_d;
  logic       clk_en_q, clk_en_d;
  logic       gnt_q, gnt_d;
  logic       rej_q, rej_d;
  logic       err_q, err_d;
  logic       closed_q, closed_d;
  logic       arf_en_q;
  logic       ld;
  logic [WW-1:0] ld_val;
  logic       wait_done;
  logic       ref_due;
  logic       ref_ack;
  logic       timer_run;
  logic       in_sref;

  sdr_wait_cnt #(.W(WW)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (wait_done)
  );

  assign in_sref   = (st_q == ST_SREF) || (st_q == ST_WAKE);
  assign timer_run = arf_en_q && !in_sref && (st_q != ST_XSR);

  sdr_ref_timer #(.INTERVAL(REF_INT)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (timer_run),
    .ack_i  (ref_ack),
    .due_o  (ref_due)
  );

  always_comb begin
    st_d     = st_q;
    pin_d    = PIN_NOP;
    cke_d    = cke_q;
    clk_en_d = clk_en_q;
    gnt_d    = 1'b0;
    rej_d    = 1'b0;
    err_d    = 1'b0;
    closed_d = closed_q;
    ld       = 1'b0;
    ld_val   = '0;
    ref_ack  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        // software command outranks a pending refresh, which outranks access
        if (cmd_we_i && cmd_i == OP_PRE_ALL) begin
          st_d     = ST_PRE;
          pin_d    = PIN_PRE;
          closed_d = 1'b1;
          ld       = 1'b1;
          ld_val   = WW'(TRP - 1);
        end else if (cmd_we_i && cmd_i == OP_SR_ENTER) begin
          if (closed_q) begin
            st_d    = ST_SREF;
            pin_d   = PIN_REF;
            cke_d   = 1'b0;
            ref_ack = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end else if (ref_due) begin
          if (closed_q) begin
            st_d    = ST_ARF;
            pin_d   = PIN_REF;
            ref_ack = 1'b1;
            ld      = 1'b1;
            ld_val  = WW'(TRFC - 1);
          end else begin
            st_d     = ST_PRE;
            pin_d    = PIN_PRE;
            closed_d = 1'b1;
            ld       = 1'b1;
            ld_val   = WW'(TRP - 1);
          end
        end else if (req_i) begin
          st_d     = ST_ACC;
          pin_d    = PIN_ACT;
          gnt_d    = 1'b1;
          closed_d = 1'b0;
          ld       = 1'b1;
          ld_val   = WW'(TACC - 1);
        end
      end
      ST_ACC, ST_PRE, ST_ARF, ST_XSR: begin
        if (wait_done) st_d = ST_IDLE;
      end
      ST_SREF: begin
        clk_en_d = 1'b0;
        rej_d    = req_i;
        if (cmd_we_i && cmd_i == OP_SR_EXIT) begin
          st_d     = ST_WAKE;
          clk_en_d = 1'b1;
          ld       = 1'b1;
          ld_val   = WW'(TWAKE - 1);
        end
      end
      ST_WAKE: begin
        rej_d = req_i;
        if (wait_done) begin
          st_d   = ST_XSR;
          cke_d  = 1'b1;
          ld     = 1'b1;
          ld_val = WW'(TXSR - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pin_q    <= PIN_NOP;
      cke_q    <= 1'b1;
      clk_en_q <= 1'b1;
      gnt_q    <= 1'b0;
      rej_q    <= 1'b0;
      err_q    <= 1'b0;
      closed_q <= 1'b0;
      arf_en_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      pin_q    <= pin_d;
      cke_q    <= cke_d;
      clk_en_q <= clk_en_d;
      gnt_q    <= gnt_d;
      rej_q    <= rej_d;
      err_q    <= err_d;
      closed_q <= closed_d;
      if (arf_we_i) arf_en_q <= arf_en_i;
    end
  end

  assign gnt_o       = gnt_q;
  assign rej_o       = rej_q;
  assign err_o       = err_q;
  assign busy_o      = (st_q == ST_ACC) || (st_q == ST_PRE) || (st_q == ST_ARF) ||
                       (st_q == ST_WAKE) || (st_q == ST_XSR);
  assign sref_o      = in_sref;
  assign sd_cs_n_o   = pin_q.cs_n;
  assign sd_ras_n_o  = pin_q.ras_n;
  assign sd_cas_n_o  = pin_q.cas_n;
  assign sd_we_n_o   = pin_q.we_n;
  assign sd_cke_o    = cke_q;
  assign sd_clk_en_o = clk_en_q;
  assign sd_dqm_o    = (st_q != ST_ACC);

  a_r3_entry_is_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_q) |-> (pin_q == PIN_REF));

  a_r4_err_keeps_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (cke_q && !sref_o));

  a_r5_no_ref_in_sref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sref_o && $past(sref_o)) |-> (pin_q != PIN_REF));

  a_r5_clock_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SREF && $past(st_q) == ST_SREF) |-> !clk_en_q);

  a_r6_no_grant_in_sref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sref_o |-> !gnt_q);

  a_r7_clock_before_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_q) |-> (clk_en_q && $past(clk_en_q)));

  a_r8_ref_banks_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_q == PIN_REF) |-> closed_q);

  a_r9_no_cmd_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACC && $past(st_q) == ST_ACC) |-> (pin_q == PIN_NOP));

endmodule

// File: tb/sdr_sref_seq_tb.sv
module sdr_sref_seq_tb;

  localparam int TRP     = 3;
  localparam int TRFC    = 7;
  localparam int TACC    = 4;
  localparam int TWAKE   = 2;
  localparam int TXSR    = 10;
  localparam int REF_INT = 200;

  localparam int P_NOP = 7;
  localparam int P_PRE = 2;
  localparam int P_REF = 1;
  localparam int P_ACT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_we_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic arf_we_i = 1'b0;
  logic arf_en_i = 1'b0;
  logic req_i = 1'b0;
  logic gnt_o, rej_o, err_o, busy_o, sref_o;
  logic sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
  logic sd_cke_o, sd_clk_en_o, sd_dqm_o;

  always #10 clk = ~clk;

  sdr_sref_seq #(
    .TRP(TRP), .TRFC(TRFC), .TACC(TACC),
    .TWAKE(TWAKE), .TXSR(TXSR), .REF_INT(REF_INT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
    .arf_we_i(arf_we_i), .arf_en_i(arf_en_i), .req_i(req_i),
    .gnt_o(gnt_o), .rej_o(rej_o), .err_o(err_o), .busy_o(busy_o), .sref_o(sref_o),
    .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o),
    .sd_we_n_o(sd_we_n_o), .sd_cke_o(sd_cke_o), .sd_clk_en_o(sd_clk_en_o),
    .sd_dqm_o(sd_dqm_o)
  );

  int checks = 0;
  int errors = 0;

  function automatic int pins();
    return int'({sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o});
  endfunction

  function automatic int slack();
    return TACC + TRP + 2;
  endfunction

  function automatic int ref_lo(int cyc);
    return cyc / (REF_INT + slack()) - 1;
  endfunction

  function automatic int ref_hi(int cyc);
    return cyc / (REF_INT - slack()) + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // monitor: bank model, invariants, refresh spacing
  int  mon_err = 0;
  int  ref_cnt = 0;
  int  gnt_cnt = 0;
  int  cyc = 0;
  int  last_ref = -1;
  int  acc_left = 0;
  bit  bank_open = 1'b1;
  bit  prev_sref = 1'b0;
  bit  gap_on = 1'b0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      bank_open = 1'b1;
      acc_left  = 0;
      prev_sref = 1'b0;
      last_ref  = -1;
    end else begin
      int p;
      p = pins();
      cyc++;
      if (p == P_ACT) begin
        bank_open = 1'b1;
        acc_left  = TACC - 1;
        gnt_cnt++;
      end else begin
        if (acc_left > 0 && (p == P_PRE || p == P_REF)) begin
          mon_err++;
          $display("FAIL R9 command %0d during access actual=%0d expected=%0d", p, p, P_NOP);
        end
        if (acc_left > 0) acc_left--;
      end
      if (p == P_PRE) bank_open = 1'b0;
      if (p == P_REF && sd_cke_o) begin
        if (bank_open) begin
          mon_err++;
          $display("FAIL R8 refresh with open bank actual=1 expected=0");
        end
        ref_cnt++;
        if (gap_on && last_ref >= 0 &&
            (cyc - last_ref < REF_INT - slack() || cyc - last_ref > REF_INT + slack())) begin
          mon_err++;
          $display("FAIL R8 refresh gap actual=%0d expected=%0d", cyc - last_ref, REF_INT);
        end
        last_ref = gap_on ? cyc : -1;
      end
      if (sref_o && prev_sref && p == P_REF) begin
        mon_err++;
        $display("FAIL R5 refresh in self refresh actual=%0d expected=%0d", p, P_NOP);
      end
      if (gnt_o && sref_o) begin
        mon_err++;
        $display("FAIL R6 grant in self refresh actual=1 expected=0");
      end
      prev_sref = sref_o;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_cmd(logic [2:0] c);
    cmd_i = c;
    cmd_we_i = 1'b1;
    step();
    cmd_we_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 1000) begin step(); n++; end
  endtask

  task automatic go_idle();
    req_i = 1'b0;
    cmd_we_i = 1'b0;
    wait_idle();
    if (sref_o) begin
      wr_cmd(3'b110);
      wait_idle();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + mon_err + 1);
    $finish;
  end

  initial begin
    int r0, busy_n, cke_at, bad;
    void'($urandom(32'd4242));
    repeat (3) step();
    rst_ni = 1'b1;
    step();

    // R1 reset state
    chk("R1 cke", int'(sd_cke_o), 1);
    chk("R1 clk_en", int'(sd_clk_en_o), 1);
    chk("R1 dqm", int'(sd_dqm_o), 1);
    chk("R1 pins", pins(), P_NOP);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 sref", int'(sref_o), 0);

    // R4 entry with no precharge since reset
    wr_cmd(3'b101);
    chk("R4 err", int'(err_o), 1);
    chk("R4 cke", int'(sd_cke_o), 1);
    chk("R4 sref", int'(sref_o), 0);
    chk("R4 pins", pins(), P_NOP);

    // R2 precharge; R10 entry write while busy is ignored
    wr_cmd(3'b010);
    chk("R2 pins", pins(), P_PRE);
    cmd_i = 3'b101; cmd_we_i = 1'b1;
    busy_n = 0;
    while (busy_o && busy_n < 100) begin busy_n++; step(); cmd_we_i = 1'b0; end
    chk("R2 busy length", busy_n, TRP);
    chk("R10 busy write ignored sref", int'(sref_o), 0);
    chk("R10 busy write ignored cke", int'(sd_cke_o), 1);

    // R10 unknown code and exit while idle
    wr_cmd(3'b011);
    chk("R10 unknown code pins", pins(), P_NOP);
    chk("R10 unknown code busy", int'(busy_o), 0);
    wr_cmd(3'b110);
    chk("R10 exit when idle pins", pins(), P_NOP);
    chk("R10 exit when idle cke", int'(sd_cke_o), 1);

    // R3 entry
    wr_cmd(3'b101);
    chk("R3 pins", pins(), P_REF);
    chk("R3 cke", int'(sd_cke_o), 0);
    chk("R3 sref", int'(sref_o), 1);
    chk("R3 clk_en entry cycle", int'(sd_clk_en_o), 1);
    step();
    chk("R5 clk_en gated", int'(sd_clk_en_o), 0);
    chk("R3 pins after entry", pins(), P_NOP);

    // R10 precharge in self refresh ignored
    wr_cmd(3'b010);
    chk("R10 pre in sref pins", pins(), P_NOP);
    chk("R10 pre in sref busy", int'(busy_o), 0);

    // R6 request refused
    req_i = 1'b1;
    step();
    chk("R6 rej", int'(rej_o), 1);
    chk("R6 gnt", int'(gnt_o), 0);
    req_i = 1'b0;

    // R5 timer enabled during self refresh: nothing issued
    arf_en_i = 1'b1; arf_we_i = 1'b1; step(); arf_we_i = 1'b0;
    r0 = ref_cnt;
    bad = 0;
    for (int i = 0; i < 2 * REF_INT; i++) begin
      step();
      if (sd_cke_o || sd_clk_en_o) bad++;
    end
    chk("R5 no refresh in sref", ref_cnt - r0, 0);
    chk("R3 cke held low", bad, 0);

    // R7 exit
    wr_cmd(3'b110);
    chk("R7 clk_en first", int'(sd_clk_en_o), 1);
    chk("R7 cke still low", int'(sd_cke_o), 0);
    busy_n = 0; cke_at = 0; bad = 0;
    while (busy_o && busy_n < 100) begin
      busy_n++;
      if (cke_at == 0 && sd_cke_o) cke_at = busy_n;
      if (pins() != P_NOP || !sd_clk_en_o) bad++;
      step();
    end
    chk("R7 cke rise cycle", cke_at, TWAKE + 1);
    chk("R7 busy length", busy_n, TWAKE + TXSR);
    chk("R7 nop during exit", bad, 0);
    chk("R7 sref cleared", int'(sref_o), 0);

    // R12 access
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    chk("R12 gnt", int'(gnt_o), 1);
    chk("R12 pins", pins(), P_ACT);
    chk("R12 dqm", int'(sd_dqm_o), 0);
    busy_n = 0;
    while (busy_o && busy_n < 100) begin busy_n++; step(); end
    chk("R12 busy length", busy_n, TACC);
    chk("R12 gnt single", int'(gnt_o), 0);

    // R4 entry after access without precharge
    wr_cmd(3'b101);
    chk("R4 err after access", int'(err_o), 1);
    chk("R4 cke after access", int'(sd_cke_o), 1);

    // R8 refresh with bank open needs precharge first (monitor checks order)
    r0 = ref_cnt;
    for (int i = 0; i < REF_INT + slack() + 4 && ref_cnt == r0; i++) step();
    chk("R8 refresh issued", int'(ref_cnt > r0), 1);

    // random requests, timer on, R8/R9 spacing and ordering
    wait_idle();
    gap_on = 1'b1;
    r0 = ref_cnt;
    busy_n = gnt_cnt;
    for (int i = 0; i < 1500; i++) begin
      req_i = ($urandom % 3 == 0);
      step();
    end
    req_i = 1'b0;
    gap_on = 1'b0;
    chk_rng("R8 refresh count", ref_cnt - r0, ref_lo(1500), ref_hi(1500));
    chk("R12 grants in random phase", int'(gnt_cnt > busy_n), 1);

    // random commands mixed with requests
    for (int i = 0; i < 2000; i++) begin
      int pick;
      req_i = ($urandom % 4 == 0);
      cmd_we_i = ($urandom % 40 == 0);
      pick = $urandom % 4;
      cmd_i = (pick == 0) ? 3'b010 : (pick == 1) ? 3'b101 : (pick == 2) ? 3'b110 : 3'b011;
      step();
    end
    go_idle();

    // R11 reset in self refresh
    wr_cmd(3'b010);
    wait_idle();
    wr_cmd(3'b101);
    chk("R11 in sref before reset", int'(sref_o), 1);
    step();
    rst_ni = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
    chk("R11 cke", int'(sd_cke_o), 1);
    chk("R11 clk_en", int'(sd_clk_en_o), 1);
    chk("R11 sref", int'(sref_o), 0);
    chk("R11 busy", int'(busy_o), 0);
    r0 = ref_cnt;
    repeat (3 * REF_INT) step();
    chk("R11 timer off after reset", ref_cnt - r0, 0);

    // monitor categories
    checks += 4;
    errors += mon_err;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule